// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits in front of the two ALU operand inputs of the execute stage (stage 3) of a five-stage in-order pipeline. Without it, an instruction that reads a register still being produced by an older instruction would see a stale latched operand. The unit compares the two source register numbers of the instruction in stage 3 with the destination numbers of the instructions in stages 4 and 5. On a match it replaces the latched operand with the result value that the older instruction carries.

Each operand input makes its own choice among three values: the latched operand, the stage-4 result, or the stage-5 result. The unit also outputs the select codes, so the surrounding pipeline and its checkers can see which path was taken. Register results from ALU operations can be forwarded from either stage. A memory load delivers its data only at the end of stage 4, so a load can be forwarded from stage 5 but never from stage 4. The stall that covers that gap belongs to other logic.

The block is purely combinational. Both source register fields must be carried down to stage 3 alongside the opcode class so that they are available here for the comparison.

Top module: `alu_fwd_unit`

## Requirements
- R1: When stage 3 and stage 4 both hold ALU-class instructions (class code 1) and the stage-4 destination equals the stage-3 rb field, `x_sel` is 1 and `x_op` equals `z4`.
- R2: When stage 3 and stage 4 both hold ALU-class instructions, stage 3 is not an immediate form, and the stage-4 destination equals the stage-3 rc field, `y_sel` is 1 and `y_op` equals `z4`.
- R3: When stage 5 holds an ALU-class or load-class (code 2) instruction whose destination equals rb of an ALU-class stage-3 instruction, and stage 4 gives no match for rb, `x_sel` is 2 and `x_op` equals `z5`.
- R4: The stage-5 rule of R3 applies in the same way to rc and the Y input, except when stage 3 is an immediate form.
- R5: When both stage 4 and stage 5 match the same source, the stage-4 result is chosen (select code 1).
- R6: A load-class instruction in stage 4 never causes a forward from stage 4, whatever its destination.
- R7: When `s3_imm` is 1, `y_sel` is 0 and `y_op` equals `y3`, whatever the destinations in stages 4 and 5.
- R8: With no match on an input, its select is 0 and its output equals the latched operand (`x3` or `y3`) unchanged.
- R9: When stage 3 is not ALU-class, both selects are 0 and both latched operands pass through.
- R10: Producers of class NOP (0), address-load (3), store (4), branch (5) and branch-and-link (6) never forward, even when their destination field matches.
- R11: The X and Y inputs choose independently. In one cycle, X and Y may take different sources, or both may take the same stage result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s3_cls | input | 3 | Opcode class of the stage-3 instruction |
| s3_rb | input | REG_W | First source register number in stage 3 |
| s3_rc | input | REG_W | Second source register number in stage 3 |
| s3_imm | input | 1 | Stage-3 instruction takes its second operand from a constant |
| x3 | input | DATA_W | Latched first ALU operand |
| y3 | input | DATA_W | Latched second ALU operand |
| s4_cls | input | 3 | Opcode class of the stage-4 instruction |
| s4_dst | input | REG_W | Destination register number in stage 4 |
| z4 | input | DATA_W | Result value held in stage 4 |
| s5_cls | input | 3 | Opcode class of the stage-5 instruction |
| s5_dst | input | REG_W | Destination register number in stage 5 |
| z5 | input | DATA_W | Result value held in stage 5 |
| x_op | output | DATA_W | First operand delivered to the ALU |
| y_op | output | DATA_W | Second operand delivered to the ALU |
| x_sel | output | 2 | X source: 0 latched, 1 stage 4, 2 stage 5 |
| y_sel | output | 2 | Y source: 0 latched, 1 stage 4, 2 stage 5 |

## Verification
Whenever the inputs settle, the bound assertions check the following: the stage-4 and stage-5 match rules on each input, that the immediate form keeps Y on its latched value, that a stage-4 load and a non-ALU consumer never forward, and that each output agrees with its select code. The assertions only relate signals to each other, so they cannot show that the rules fire for the right cases. The bench's scenarios provide that evidence. They cover distance-1 and distance-2 dependences on each input alone and on both together, priority when both stages match, a load in each stage, and a sweep of every destination number for a single source register.

// File: rtl/alu_fwd_pkg.sv
package alu_fwd_pkg;

  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_LADR   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_BRL    = 3'd6
  } op_class_e;

  typedef enum logic [1:0] {
    SRC_LATCH = 2'd0,
    SRC_Z4    = 2'd1,
    SRC_Z5    = 2'd2
  } src_sel_e;

  // A producer may feed a forward when its result exists in the stage it sits in.
  // Load data exists only after the memory stage, i.e. in the late stage.
  function automatic logic can_forward(input logic [2:0] cls, input logic late);
    return (cls == CLS_ALU) || (late && (cls == CLS_LOAD));
  endfunction

  // Nearer producer is younger, so it wins.
  function automatic src_sel_e pick_source(input logic hit_near, input logic hit_far);
    if (hit_near)     return SRC_Z4;
    else if (hit_far) return SRC_Z5;
    else              return SRC_LATCH;
  endfunction

endpackage

// File: rtl/alu_fwd_match.sv
module alu_fwd_match
  import alu_fwd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter bit LATE  = 1'b0
) (
  input  logic [2:0]       prod_cls,
  input  logic [REG_W-1:0] prod_dst,
  input  logic             cons_alu,
  input  logic             src_live,
  input  logic [REG_W-1:0] cons_src,
  output logic             hit
);

  logic dst_eq;
  logic prod_ok;

  assign dst_eq  = (prod_dst == cons_src);
  assign prod_ok = can_forward(prod_cls, LATE);
  assign hit     = cons_alu && src_live && prod_ok && dst_eq;

endmodule

// File: rtl/alu_fwd_mux.sv
module alu_fwd_mux
  import alu_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] latched,
  input  logic [DATA_W-1:0] near_val,
  input  logic [DATA_W-1:0] far_val,
  input  logic              hit_near,
  input  logic              hit_far,
  output logic [1:0]        sel,
  output logic [DATA_W-1:0] val
);

  src_sel_e choice;

  assign choice = pick_source(hit_near, hit_far);
  assign sel    = choice;

  always_comb begin
    case (choice)
      SRC_Z4:  val = near_val;
      SRC_Z5:  val = far_val;
      default: val = latched;
    endcase
  end

endmodule

// File: rtl/alu_fwd_unit.sv
module alu_fwd_unit
  import alu_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [2:0]        s3_cls,
  input  logic [REG_W-1:0]  s3_rb,
  input  logic [REG_W-1:0]  s3_rc,
  input  logic              s3_imm,
  input  logic [DATA_W-1:0] x3,
  input  logic [DATA_W-1:0] y3,
  input  logic [2:0]        s4_cls,
  input  logic [REG_W-1:0]  s4_dst,
  input  logic [DATA_W-1:0] z4,
  input  logic [2:0]        s5_cls,
  input  logic [REG_W-1:0]  s5_dst,
  input  logic [DATA_W-1:0] z5,
  output logic [DATA_W-1:0] x_op,
  output logic [DATA_W-1:0] y_op,
  output logic [1:0]        x_sel,
  output logic [1:0]        y_sel
);

  localparam int NSTAGE = 2;  // index 0: stage 4, index 1: stage 5
  localparam int NOPND  = 2;  // index 0: X, index 1: Y

  logic              cons_alu;
  logic [2:0]        prod_cls [NSTAGE];
  logic [REG_W-1:0]  prod_dst [NSTAGE];
  logic [REG_W-1:0]  cons_src [NOPND];
  logic              src_live [NOPND];
  logic [DATA_W-1:0] opnd_in  [NOPND];
  logic [DATA_W-1:0] opnd_out [NOPND];
  logic [1:0]        sel_out  [NOPND];
  logic [NOPND-1:0]  hit      [NSTAGE];

  // Named match events, visible to the bound checker
  logic hit4_x, hit4_y, hit5_x, hit5_y;

  assign cons_alu    = (s3_cls == CLS_ALU);
  assign prod_cls[0] = s4_cls;
  assign prod_cls[1] = s5_cls;
  assign prod_dst[0] = s4_dst;
  assign prod_dst[1] = s5_dst;
  assign cons_src[0] = s3_rb;
  assign cons_src[1] = s3_rc;
  assign src_live[0] = 1'b1;
  assign src_live[1] = ~s3_imm;   // constant second operand is never replaced
  assign opnd_in[0]  = x3;
  assign opnd_in[1]  = y3;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    for (genvar o = 0; o < NOPND; o++) begin : g_opnd
      alu_fwd_match #(
        .REG_W (REG_W),
        .LATE  (g == 1)
      ) u_match (
        .prod_cls (prod_cls[g]),
        .prod_dst (prod_dst[g]),
        .cons_alu (cons_alu),
        .src_live (src_live[o]),
        .cons_src (cons_src[o]),
        .hit      (hit[g][o])
      );
    end
  end

  assign hit4_x = hit[0][0];
  assign hit4_y = hit[0][1];
  assign hit5_x = hit[1][0];
  assign hit5_y = hit[1][1];

  for (genvar o = 0; o < NOPND; o++) begin : g_mux
    alu_fwd_mux #(
      .DATA_W (DATA_W)
    ) u_mux (
      .latched  (opnd_in[o]),
      .near_val (z4),
      .far_val  (z5),
      .hit_near (hit[0][o]),
      .hit_far  (hit[1][o]),
      .sel      (sel_out[o]),
      .val      (opnd_out[o])
    );
  end

  assign x_op  = opnd_out[0];
  assign y_op  = opnd_out[1];
  assign x_sel = sel_out[0];
  assign y_sel = sel_out[1];

endmodule

// File: rtl/alu_fwd_unit_chk.sv
module alu_fwd_unit_chk
  import alu_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [2:0]        s3_cls,
  input logic [REG_W-1:0]  s3_rb,
  input logic [REG_W-1:0]  s3_rc,
  input logic              s3_imm,
  input logic [DATA_W-1:0] x3,
  input logic [DATA_W-1:0] y3,
  input logic [2:0]        s4_cls,
  input logic [REG_W-1:0]  s4_dst,
  input logic [DATA_W-1:0] z4,
  input logic [2:0]        s5_cls,
  input logic [REG_W-1:0]  s5_dst,
  input logic [DATA_W-1:0] z5,
  input logic [DATA_W-1:0] x_op,
  input logic [DATA_W-1:0] y_op,
  input logic [1:0]        x_sel,
  input logic [1:0]        y_sel,
  input logic              hit4_x,
  input logic              hit4_y,
  input logic              hit5_x,
  input logic              hit5_y
);

  logic c3_alu, c4_alu, c5_prod;
  assign c3_alu  = (s3_cls == CLS_ALU);
  assign c4_alu  = (s4_cls == CLS_ALU);
  assign c5_prod = (s5_cls == CLS_ALU) || (s5_cls == CLS_LOAD);

  always_comb begin
    // R1: distance-1 dependence on rb takes the stage-4 result
    if (c3_alu && c4_alu && (s4_dst == s3_rb))
      a_r1_near_x: assert (x_sel == 2'd1 && x_op == z4)
        else $error("a_r1_near_x");
    // R2: distance-1 dependence on rc, register form only
    if (c3_alu && c4_alu && !s3_imm && (s4_dst == s3_rc))
      a_r2_near_y: assert (y_sel == 2'd1 && y_op == z4)
        else $error("a_r2_near_y");
    // R3: distance-2 dependence on rb with no nearer producer
    if (c3_alu && c5_prod && (s5_dst == s3_rb) && !hit4_x)
      a_r3_far_x: assert (x_sel == 2'd2 && x_op == z5)
        else $error("a_r3_far_x");
    // R4: distance-2 dependence on rc with no nearer producer
    if (c3_alu && c5_prod && !s3_imm && (s5_dst == s3_rc) && !hit4_y)
      a_r4_far_y: assert (y_sel == 2'd2 && y_op == z5)
        else $error("a_r4_far_y");
    // R5: both stages matching resolves to stage 4
    if (hit4_x && hit5_x)
      a_r5_near_wins_x: assert (x_sel == 2'd1)
        else $error("a_r5_near_wins_x");
    if (hit4_y && hit5_y)
      a_r5_near_wins_y: assert (y_sel == 2'd1)
        else $error("a_r5_near_wins_y");
    // R6: load in stage 4 never forwards
    if (s4_cls == CLS_LOAD)
      a_r6_no_load4: assert (x_sel != 2'd1 && y_sel != 2'd1)
        else $error("a_r6_no_load4");
    // R7: immediate form keeps the latched Y
    if (s3_imm)
      a_r7_imm_y: assert (y_sel == 2'd0 && y_op == y3)
        else $error("a_r7_imm_y");
    // R8: no match means pass-through
    if (!hit4_x && !hit5_x)
      a_r8_pass_x: assert (x_sel == 2'd0 && x_op == x3)
        else $error("a_r8_pass_x");
    if (!hit4_y && !hit5_y)
      a_r8_pass_y: assert (y_sel == 2'd0 && y_op == y3)
        else $error("a_r8_pass_y");
    // R9: only ALU consumers are served
    if (!c3_alu)
      a_r9_non_alu: assert (x_sel == 2'd0 && y_sel == 2'd0)
        else $error("a_r9_non_alu");
    // R11: each select stays inside its code range
    a_r11_sel_range: assert (x_sel != 2'd3 && y_sel != 2'd3)
      else $error("a_r11_sel_range");
  end

endmodule

bind alu_fwd_unit alu_fwd_unit_chk #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W)
) u_chk (
  .s3_cls (s3_cls), .s3_rb (s3_rb), .s3_rc (s3_rc), .s3_imm (s3_imm),
  .x3 (x3), .y3 (y3),
  .s4_cls (s4_cls), .s4_dst (s4_dst), .z4 (z4),
  .s5_cls (s5_cls), .s5_dst (s5_dst), .z5 (z5),
  .x_op (x_op), .y_op (y_op), .x_sel (x_sel), .y_sel (y_sel),
  .hit4_x (hit4_x), .hit4_y (hit4_y), .hit5_x (hit5_x), .hit5_y (hit5_y)
);

// File: tb/alu_fwd_unit_bench.sv
module alu_fwd_unit_bench;

  localparam int DW = 32;
  localparam int RW = 5;
  localparam int WATCHDOG = 20000;

  // class codes: 0 nop, 1 alu, 2 load, 3 ladr, 4 store, 5 branch, 6 brl
  typedef struct packed {
    logic [2:0] c3; logic [4:0] rb; logic [4:0] rc; logic imm;
    logic [2:0] c4; logic [4:0] d4;
    logic [2:0] c5; logic [4:0] d5;
    logic [1:0] ex; logic [1:0] ey;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd1, 5'd3,  3'd1, 5'd4,  2'd0, 2'd0, 4'd8 },  // R8 no match
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd1, 5'd1,  3'd0, 5'd0,  2'd1, 2'd0, 4'd1 },  // R1 dist-1 on X
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd1, 5'd2,  3'd0, 5'd0,  2'd0, 2'd1, 4'd2 },  // R2 dist-1 on Y
    '{3'd1, 5'd5,  5'd5,  1'b0, 3'd1, 5'd5,  3'd0, 5'd0,  2'd1, 2'd1, 4'd11},  // R11 both from Z4
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd0, 5'd0,  3'd1, 5'd1,  2'd2, 2'd0, 4'd3 },  // R3 dist-2 on X
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd0, 5'd0,  3'd1, 5'd2,  2'd0, 2'd2, 4'd4 },  // R4 dist-2 on Y
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd1, 5'd1,  3'd1, 5'd2,  2'd1, 2'd2, 4'd11},  // R11 split sources
    '{3'd1, 5'd7,  5'd3,  1'b0, 3'd1, 5'd7,  3'd1, 5'd7,  2'd1, 2'd0, 4'd5 },  // R5 X both match
    '{3'd1, 5'd4,  5'd7,  1'b0, 3'd1, 5'd7,  3'd1, 5'd7,  2'd0, 2'd1, 4'd5 },  // R5 Y both match
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd2, 5'd1,  3'd0, 5'd0,  2'd0, 2'd0, 4'd6 },  // R6 load in stage 4
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd2, 5'd1,  3'd1, 5'd1,  2'd2, 2'd0, 4'd6 },  // R6 load4 falls to Z5
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd0, 5'd0,  3'd2, 5'd1,  2'd2, 2'd0, 4'd3 },  // R3 load in stage 5
    '{3'd1, 5'd1,  5'd2,  1'b1, 3'd1, 5'd2,  3'd0, 5'd0,  2'd0, 2'd0, 4'd7 },  // R7 imm, dist-1 on rc
    '{3'd1, 5'd3,  5'd2,  1'b1, 3'd1, 5'd3,  3'd1, 5'd2,  2'd1, 2'd0, 4'd7 },  // R7 imm, X still forwards
    '{3'd4, 5'd1,  5'd2,  1'b0, 3'd1, 5'd1,  3'd1, 5'd2,  2'd0, 2'd0, 4'd9 },  // R9 store consumer
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd3, 5'd1,  3'd6, 5'd2,  2'd0, 2'd0, 4'd10},  // R10 ladr / brl producers
    '{3'd1, 5'd1,  5'd2,  1'b0, 3'd4, 5'd1,  3'd5, 5'd2,  2'd0, 2'd0, 4'd10},  // R10 store / branch producers
    '{3'd1, 5'd31, 5'd30, 1'b0, 3'd1, 5'd30, 3'd1, 5'd31, 2'd2, 2'd1, 4'd11}   // R11 cross, top registers
  };

  logic          clk = 1'b0;
  logic [2:0]    s3_cls, s4_cls, s5_cls;
  logic [RW-1:0] s3_rb, s3_rc, s4_dst, s5_dst;
  logic          s3_imm;
  logic [DW-1:0] x3, y3, z4, z5, x_op, y_op;
  logic [1:0]    x_sel, y_sel;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu_fwd_unit #(.DATA_W(DW), .REG_W(RW)) u_alu_fwd_unit (
    .s3_cls (s3_cls), .s3_rb (s3_rb), .s3_rc (s3_rc), .s3_imm (s3_imm),
    .x3 (x3), .y3 (y3),
    .s4_cls (s4_cls), .s4_dst (s4_dst), .z4 (z4),
    .s5_cls (s5_cls), .s5_dst (s5_dst), .z5 (z5),
    .x_op (x_op), .y_op (y_op), .x_sel (x_sel), .y_sel (y_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] l,
                                         input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (s == 2'd1) ? a : (s == 2'd2) ? b : l;
  endfunction

  task automatic drive(input logic [2:0] c3, input logic [4:0] rb, input logic [4:0] rc,
                       input logic imm, input logic [2:0] c4, input logic [4:0] d4,
                       input logic [2:0] c5, input logic [4:0] d5, input int tag);
    @(negedge clk);
    s3_cls = c3; s3_rb = rb; s3_rc = rc; s3_imm = imm;
    s4_cls = c4; s4_dst = d4; s5_cls = c5; s5_dst = d5;
    x3 = 32'hA000_0000 + tag; y3 = 32'hB000_0000 + tag;
    z4 = 32'hC000_0000 + tag; z5 = 32'hD000_0000 + tag;
    @(posedge clk);
    #1;
  endtask

  initial begin
    s3_cls = '0; s3_rb = '0; s3_rc = '0; s3_imm = 1'b0;
    s4_cls = '0; s4_dst = '0; s5_cls = '0; s5_dst = '0;
    x3 = '0; y3 = '0; z4 = '0; z5 = '0;

    // Idle pipe after reset: all nops, all register fields zero -> R8 pass-through
    drive(3'd0, 5'd0, 5'd0, 1'b0, 3'd0, 5'd0, 3'd0, 5'd0, 900);
    check("R8", "idle x_sel", {30'd0, x_sel}, 0);
    check("R8", "idle y_sel", {30'd0, y_sel}, 0);
    check("R8", "idle x_op", x_op, 32'hA000_0000 + 900);
    check("R8", "idle y_op", y_op, 32'hB000_0000 + 900);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string r = $sformatf("R%0d vec%0d", v.req, i);
      drive(v.c3, v.rb, v.rc, v.imm, v.c4, v.d4, v.c5, v.d5, i);
      check(r, "x_sel", {30'd0, x_sel}, {30'd0, v.ex});
      check(r, "y_sel", {30'd0, y_sel}, {30'd0, v.ey});
      check(r, "x_op", x_op, pick(v.ex, 32'hA000_0000 + i, 32'hC000_0000 + i, 32'hD000_0000 + i));
      check(r, "y_op", y_op, pick(v.ey, 32'hB000_0000 + i, 32'hC000_0000 + i, 32'hD000_0000 + i));
    end

    // R1 boundary: sweep every stage-4 destination; only rb=9 may forward to X
    for (int d = 0; d < 32; d++) begin
      drive(3'd1, 5'd9, 5'd20, 1'b1, 3'd1, 5'(d), 3'd0, 5'd0, 100 + d);
      check("R1", $sformatf("sweep dst %0d x_sel", d), {30'd0, x_sel}, (d == 9) ? 1 : 0);
    end

    // R4 with R7: immediate also blocks a stage-5 match on rc
    drive(3'd1, 5'd1, 5'd6, 1'b1, 3'd0, 5'd0, 3'd2, 5'd6, 300);
    check("R7", "imm stage5 y_op", y_op, 32'hB000_0000 + 300);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule